// File: doc/BRIEF.md
# Debug Event Monitor

This block watches the stream of committed instructions and raises a debug interruption request when one of four watched event classes occurs. The classes are a taken branch, a write to one of a chosen set of general registers, an instruction fetched from a watched storage window, and a store into that same window. Software programs a 32-bit control word that enables each class on its own and picks the watched registers. Two addresses bound the storage window. The block is live only when the extended control mode flag and the debug mask bit of the status word are both set.

Each committed instruction gives one cycle of `cm_valid` with its strobes. If any enabled class matches, the block registers a record that holds a 4-bit class code and the address of the causing instruction, and it raises `evt_valid`. The record is a valid/ready output. It stays on the port, unchanged, until a cycle in which `evt_ready` is high, and that cycle is the acknowledge. The block never stalls the commit side. A matching instruction that arrives while a record is waiting and not being accepted is dropped. A match that arrives while monitoring is disabled is also dropped. Neither kind of match is kept for later.

Top module: `dbg_evt_monitor`

## Requirements
- R1: After reset, `evt_valid` is 0.
- R2: When control word bit 0 (the MSB, `ctl_word[31]`) is set, a committed taken branch raises a record with code bit 3 set.
- R3: Register n (0..15) is watched when control word bit 16+n (`ctl_word[15-n]`) is set. A committed write to a watched register sets code bit 2 when class bit 1 (`ctl_word[30]`) is set. A write to an unwatched register sets nothing.
- R4: When class bit 2 (`ctl_word[29]`) is set, a committed instruction whose address lies in the window sets code bit 1.
- R5: When class bit 3 (`ctl_word[28]`) is set, a committed store whose address lies in the window sets code bit 0.
- R6: The window comparison includes both ends. When `range_lo` is less than or equal to `range_hi`, an address matches if lo <= a <= hi. When `range_lo` is greater than `range_hi`, the window wraps, and an address matches if a >= lo or a <= hi.
- R7: No record is raised unless `ext_mode` and `per_mask` are both 1. A match seen while either one is 0 is discarded, and it is not reported after the flags are set again.
- R8: A class whose enable bit is 0 never appears in the code. All enabled classes that match on the same instruction appear together in one code.
- R9: While `evt_valid` is 1 and `evt_ready` is 0, the code and the address stay stable, and new matches are discarded. A match in a cycle where `evt_ready` is 1 replaces the record that is being accepted.
- R10: The record appears on the clock edge that samples the commit, and `evt_iaddr` equals that commit's `cm_iaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | Extended control mode active |
| per_mask | input | 1 | Status-word debug mask bit |
| ctl_word | input | 32 | Class enables (bits 0-3, MSB first) and register select (bits 16-31) |
| range_lo | input | AW | Window start address |
| range_hi | input | AW | Window end address |
| cm_valid | input | 1 | One instruction committed this cycle |
| cm_iaddr | input | AW | Address of the committed instruction |
| cm_branch | input | 1 | Instruction was a taken branch |
| cm_reg_wr | input | 1 | Instruction wrote a general register |
| cm_reg_num | input | 4 | Number of the written register |
| cm_store | input | 1 | Instruction stored to memory |
| cm_store_addr | input | AW | Store address |
| evt_valid | output | 1 | Interruption request / record valid |
| evt_ready | input | 1 | Acknowledge; record accepted when high with evt_valid |
| evt_code | output | 4 | Class code: bit3 branch, bit2 register, bit1 fetch, bit0 store |
| evt_iaddr | output | AW | Address of the causing instruction |

## Verification
A wrong window comparison shows on the next edge. A watched address that is off by one, or the wrong side of a wrapped window, gives a missing record or an extra record one cycle after the commit. A fault in the enable gating or in the register-select bit order has the same kind of effect: a record appears for a class or register that should be silent, again on the following cycle. A fault in the holding slot shows only while the acknowledge is held low. Either the record changes under back-pressure, or a dropped match surfaces once the slot drains.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  // Class positions inside the reported code
  localparam int unsigned CLS_N      = 4;
  localparam int unsigned CLS_BRANCH = 3;
  localparam int unsigned CLS_REG    = 2;
  localparam int unsigned CLS_FETCH  = 1;
  localparam int unsigned CLS_STORE  = 0;

  typedef logic [CLS_N-1:0] cls_vec_t;

  // Control word bit k (k=0 is the MSB) for a 32-bit word
  function automatic logic ctl_bit(input logic [31:0] w, input int unsigned k);
    return w[31-k];
  endfunction

  // Class enables: bit 0 -> branch, 1 -> register, 2 -> fetch, 3 -> store
  function automatic cls_vec_t class_enables(input logic [31:0] w);
    cls_vec_t e;
    e[CLS_BRANCH] = ctl_bit(w, 0);
    e[CLS_REG]    = ctl_bit(w, 1);
    e[CLS_FETCH]  = ctl_bit(w, 2);
    e[CLS_STORE]  = ctl_bit(w, 3);
    return e;
  endfunction
endpackage

// File: rtl/dbg_evt_range.sv
module dbg_evt_range #(
  parameter int unsigned AW = 24
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  logic above_lo, below_hi, wraps;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    wraps    = (lo > hi);
    hit      = wraps ? (above_lo | below_hi) : (above_lo & below_hi);
  end
endmodule

// File: rtl/dbg_evt_classify.sv
module dbg_evt_classify
  import dbg_evt_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned NREG = 16
) (
  input  logic [31:0]             ctl_word,
  input  logic [AW-1:0]           range_lo,
  input  logic [AW-1:0]           range_hi,
  input  logic [AW-1:0]           cm_iaddr,
  input  logic                    cm_branch,
  input  logic                    cm_reg_wr,
  input  logic [$clog2(NREG)-1:0] cm_reg_num,
  input  logic                    cm_store,
  input  logic [AW-1:0]           cm_store_addr,
  output cls_vec_t                raw_hits
);
  localparam int unsigned NPROBE  = 2;
  localparam int unsigned SEL_TOP = NREG - 1;

  logic [NREG-1:0]   reg_sel;
  logic [AW-1:0]     probe [NPROBE];
  logic [NPROBE-1:0] in_win;

  // Register n is selected by control-word bit 16+n, counted from the MSB
  for (genvar n = 0; n < NREG; n++) begin : g_sel
    assign reg_sel[n] = ctl_word[SEL_TOP-n];
  end

  assign probe[0] = cm_iaddr;
  assign probe[1] = cm_store_addr;

  for (genvar p = 0; p < NPROBE; p++) begin : g_win
    dbg_evt_range #(.AW(AW)) u_range (
      .addr (probe[p]),
      .lo   (range_lo),
      .hi   (range_hi),
      .hit  (in_win[p])
    );
  end

  always_comb begin
    raw_hits             = '0;
    raw_hits[CLS_BRANCH] = cm_branch;
    raw_hits[CLS_REG]    = cm_reg_wr & reg_sel[cm_reg_num];
    raw_hits[CLS_FETCH]  = in_win[0];
    raw_hits[CLS_STORE]  = cm_store & in_win[1];
  end
endmodule

// File: rtl/dbg_evt_slot.sv
module dbg_evt_slot
  import dbg_evt_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cls_vec_t      hits,
  input  logic [AW-1:0] iaddr,
  output logic          out_valid,
  input  logic          out_ready,
  output cls_vec_t      out_code,
  output logic [AW-1:0] out_addr
);
  logic free, take;

  always_comb begin
    free = ~out_valid | out_ready;
    take = (|hits) & free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_addr  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_code  <= hits;
      out_addr  <= iaddr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_evt_monitor.sv
module dbg_evt_monitor
  import dbg_evt_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned NREG = 16,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          per_mask,
  input  logic [31:0]   ctl_word,
  input  logic [AW-1:0] range_lo,
  input  logic [AW-1:0] range_hi,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_iaddr,
  input  logic          cm_branch,
  input  logic          cm_reg_wr,
  input  logic [RW-1:0] cm_reg_num,
  input  logic          cm_store,
  input  logic [AW-1:0] cm_store_addr,
  output logic          evt_valid,
  input  logic          evt_ready,
  output logic [3:0]    evt_code,
  output logic [AW-1:0] evt_iaddr
);
  cls_vec_t raw_hits, enabled_hits, slot_code;
  logic     live;

  dbg_evt_classify #(.AW(AW), .NREG(NREG)) u_classify (
    .ctl_word      (ctl_word),
    .range_lo      (range_lo),
    .range_hi      (range_hi),
    .cm_iaddr      (cm_iaddr),
    .cm_branch     (cm_branch),
    .cm_reg_wr     (cm_reg_wr),
    .cm_reg_num    (cm_reg_num),
    .cm_store      (cm_store),
    .cm_store_addr (cm_store_addr),
    .raw_hits      (raw_hits)
  );

  always_comb begin
    live         = cm_valid & ext_mode & per_mask;
    enabled_hits = raw_hits & class_enables(ctl_word) & {CLS_N{live}};
  end

  dbg_evt_slot #(.AW(AW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .hits      (enabled_hits),
    .iaddr     (cm_iaddr),
    .out_valid (evt_valid),
    .out_ready (evt_ready),
    .out_code  (slot_code),
    .out_addr  (evt_iaddr)
  );

  assign evt_code = slot_code;
endmodule

// File: rtl/dbg_evt_monitor_chk.sv
module dbg_evt_monitor_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_mode,
  input logic          per_mask,
  input logic [31:0]   ctl_word,
  input logic          cm_valid,
  input logic [AW-1:0] cm_iaddr,
  input logic          cm_branch,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic [3:0]    evt_code,
  input logic [AW-1:0] evt_iaddr
);
  // R9
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_iaddr)));

  // R8
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code != 4'b0000));

  // R7
  gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !(cm_valid && ext_mode && per_mask)) |=> !evt_valid);

  // R10
  branch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && ext_mode && per_mask && cm_branch && ctl_word[31] && (!evt_valid || evt_ready))
    |=> (evt_valid && evt_code[3] && evt_iaddr == $past(cm_iaddr)));

  // R8
  branch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && $rose(evt_valid) && !$past(ctl_word[31])) |-> !evt_code[3]);
endmodule

bind dbg_evt_monitor dbg_evt_monitor_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_mode  (ext_mode),
  .per_mask  (per_mask),
  .ctl_word  (ctl_word),
  .cm_valid  (cm_valid),
  .cm_iaddr  (cm_iaddr),
  .cm_branch (cm_branch),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_code  (evt_code),
  .evt_iaddr (evt_iaddr)
);

// File: tb/dbg_evt_monitor_bench.sv
module dbg_evt_monitor_bench;
  localparam int AW = 24;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ext_mode = 0, per_mask = 0;
  logic [31:0]   ctl_word = '0;
  logic [AW-1:0] range_lo = '0, range_hi = '0;
  logic          cm_valid = 0, cm_branch = 0, cm_reg_wr = 0, cm_store = 0;
  logic [AW-1:0] cm_iaddr = '0, cm_store_addr = '0;
  logic [3:0]    cm_reg_num = '0;
  logic          evt_valid, evt_ready = 1;
  logic [3:0]    evt_code;
  logic [AW-1:0] evt_iaddr;

  // staged configuration, applied at the falling edge
  logic          s_ext = 0, s_per = 0;
  logic [31:0]   s_ctl = '0;
  logic [AW-1:0] s_lo = '0, s_hi = '0;

  int checks = 0, failures = 0;
  logic [3:0]    q_code [$];
  logic [AW-1:0] q_addr [$];
  string         q_tag  [$];
  logic          m_busy = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  dbg_evt_monitor u_dbg_evt_monitor (
    .clk, .rst_n, .ext_mode, .per_mask, .ctl_word, .range_lo, .range_hi,
    .cm_valid, .cm_iaddr, .cm_branch, .cm_reg_wr, .cm_reg_num, .cm_store,
    .cm_store_addr, .evt_valid, .evt_ready, .evt_code, .evt_iaddr
  );

  function automatic logic in_win(input logic [AW-1:0] a);
    if (s_lo <= s_hi) return (a >= s_lo) && (a <= s_hi);
    return (a >= s_lo) || (a <= s_hi);
  endfunction

  task automatic commit(input logic br, input logic rw, input logic [3:0] rn,
                        input logic st, input logic [AW-1:0] sa,
                        input logic [AW-1:0] ia, input logic rdy, input string tag);
    logic [3:0] c;
    logic cap;
    @(negedge clk);
    ext_mode = s_ext; per_mask = s_per; ctl_word = s_ctl;
    range_lo = s_lo; range_hi = s_hi;
    cm_valid = 1; cm_branch = br; cm_reg_wr = rw; cm_reg_num = rn;
    cm_store = st; cm_store_addr = sa; cm_iaddr = ia; evt_ready = rdy;
    c = 4'b0;
    c[3] = br & s_ctl[31];
    c[2] = rw & s_ctl[30] & s_ctl[15-rn];
    c[1] = s_ctl[29] & in_win(ia);
    c[0] = st & s_ctl[28] & in_win(sa);
    if (!(s_ext && s_per)) c = 4'b0;
    cap = (c != 0) && (!m_busy || rdy);
    if (cap) begin
      q_code.push_back(c); q_addr.push_back(ia); q_tag.push_back(tag);
    end
    m_busy = cap ? 1'b1 : (m_busy && !rdy);
    @(posedge clk);
  endtask

  task automatic idle(input logic rdy);
    @(negedge clk);
    ext_mode = s_ext; per_mask = s_per; ctl_word = s_ctl;
    range_lo = s_lo; range_hi = s_hi;
    cm_valid = 0; cm_branch = 0; cm_reg_wr = 0; cm_store = 0; evt_ready = rdy;
    m_busy = m_busy && !rdy;
    @(posedge clk);
  endtask

  task automatic check_held(input logic [3:0] c, input logic [AW-1:0] a);
    #2;
    checks++;
    if (!(evt_valid && evt_code == c && evt_iaddr == a)) begin
      failures++;
      $display("FAIL R9 held record: valid=%0b code=%b addr=%h expected valid=1 code=%b addr=%h",
               evt_valid, evt_code, evt_iaddr, c, a);
    end
  endtask

  // monitor: pops one expected record on each accepted handshake
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done && evt_valid && evt_ready) begin
      checks++;
      if (q_code.size() == 0) begin
        failures++;
        $display("FAIL R7/R8 unexpected record: code=%b addr=%h expected none",
                 evt_code, evt_iaddr);
      end else begin
        logic [3:0] ec;
        logic [AW-1:0] ea;
        string t;
        ec = q_code.pop_front(); ea = q_addr.pop_front(); t = q_tag.pop_front();
        if (evt_code !== ec || evt_iaddr !== ea) begin
          failures++;
          $display("FAIL %s: code=%b addr=%h expected code=%b addr=%h",
                   t, evt_code, evt_iaddr, ec, ea);
        end
      end
    end
  end

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #23;
    checks++;
    if (evt_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: evt_valid=%b expected 0", evt_valid);
    end
    rst_n = 1;
    idle(1); idle(1);
    checks++;
    if (evt_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: evt_valid=%b expected 0", evt_valid);
    end

    s_ext = 1; s_per = 1;
    s_lo = 24'h000200; s_hi = 24'h0002FF;

    // R2 branch only
    s_ctl = 32'h8000_0000;
    commit(1, 0, 0, 0, 0, 24'h000100, 1, "R2 branch");
    idle(1);
    // R8 branch class disabled
    s_ctl = 32'h1000_0000;
    commit(1, 0, 0, 0, 24'h000010, 24'h000104, 1, "R8 branch disabled");
    idle(1);

    // R3 register 5 watched (ctl_word[10])
    s_ctl = 32'h4000_0400;
    commit(0, 1, 5, 0, 0, 24'h000108, 1, "R3 reg5 watched");
    commit(0, 1, 6, 0, 0, 24'h00010C, 1, "R3 reg6 unwatched");
    idle(1);

    // R4 / R6 fetch window edges
    s_ctl = 32'h2000_0000;
    commit(0, 0, 0, 0, 0, 24'h000200, 1, "R4 R6 fetch low edge");
    commit(0, 0, 0, 0, 0, 24'h0002FF, 1, "R4 R6 fetch high edge");
    commit(0, 0, 0, 0, 0, 24'h0001FF, 1, "R6 below");
    commit(0, 0, 0, 0, 0, 24'h000300, 1, "R6 above");
    idle(1);

    // R5 store
    s_ctl = 32'h1000_0000;
    commit(0, 0, 0, 1, 24'h000250, 24'h000010, 1, "R5 store in");
    commit(0, 0, 0, 1, 24'h000350, 24'h000014, 1, "R5 store out");
    idle(1);

    // R6 wrapped window
    s_lo = 24'hFFFF00; s_hi = 24'h000010; s_ctl = 32'h2000_0000;
    commit(0, 0, 0, 0, 0, 24'hFFFFF0, 1, "R6 wrap top");
    commit(0, 0, 0, 0, 0, 24'h000005, 1, "R6 wrap bottom");
    commit(0, 0, 0, 0, 0, 24'h800000, 1, "R6 wrap gap");
    idle(1);

    // R8 several classes on one instruction
    s_lo = 24'h000200; s_hi = 24'h0002FF; s_ctl = 32'hF000_FFFF;
    commit(1, 1, 0, 1, 24'h000210, 24'h000020, 1, "R8 combined");
    idle(1);

    // R7 gating: masked then unmasked, nothing deferred
    s_per = 0;
    commit(1, 0, 0, 0, 0, 24'h000030, 1, "R7 per off");
    s_per = 1; s_ext = 0;
    commit(1, 0, 0, 0, 0, 24'h000034, 1, "R7 ext off");
    s_ext = 1;
    idle(1); idle(1); idle(1);

    // R9 hold under back-pressure, drop while held, replace on accept
    s_ctl = 32'h8000_0000;
    commit(1, 0, 0, 0, 0, 24'h000040, 0, "R9 R10 held first");
    check_held(4'b1000, 24'h000040);
    commit(1, 0, 0, 0, 0, 24'h000044, 0, "R9 dropped");
    check_held(4'b1000, 24'h000040);
    idle(0);
    check_held(4'b1000, 24'h000040);
    commit(1, 0, 0, 0, 0, 24'h000048, 1, "R9 replace on accept");
    idle(1); idle(1); idle(1);

    done = 1;
    checks++;
    if (q_code.size() != 0) begin
      failures++;
      $display("FAIL R10 missing records: pending=%0d expected 0", q_code.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule